// File: doc/BRIEF.md
# Completion Counter Interrupt Register

This block is the interrupt status register of one DMA channel. Each time the channel reports a finished transfer with a one-cycle pulse, a 6-bit completion count advances by one. The interrupt output is raised whenever that count differs from a firmware-owned acknowledge field.

Firmware reads the register to learn the current count. It then writes that count back into the acknowledge field. If both fields match, the interrupt drops. If another completion arrived between the read and the write, the two fields still differ and the interrupt stays high, so no event is lost.

The register sits on a simple slave port with a select, a write enable, 32-bit write data and 32-bit registered read data. The reset is synchronous and active high.

Top module: `cack_irq_reg`

## Requirements
- R1: During and right after reset, the count, the acknowledge field, the read data and the interrupt output are all zero.
- R2: Each cycle with `done_pulse` high raises the count by exactly one. The count is visible in read-data bits 29:24.
- R3: The count wraps from 63 to 0 on the next completion, and the interrupt is asserted after the wrap if the acknowledge field is 63.
- R4: `irq` is a registered output that is high exactly when the count and the acknowledge field differ. It takes its new value on the same clock edge that updates either field.
- R5: A write (`reg_sel` and `reg_wr` high) loads write-data bits 5:0 into the acknowledge field. That field reads back in read-data bits 5:0.
- R6: Write-data bits 29:24 never change the count.
- R7: Read-data bits 31:30 and 23:6 always read zero, whatever was written to them.
- R8: When a completion and an acknowledge write fall in the same cycle, the count still increments. The interrupt is judged against the incremented count, so acknowledging the old value leaves `irq` high.
- R9: A read (`reg_sel` high, `reg_wr` low) presents, one clock later on `reg_rdata`, the fields as they stood before that edge. `reg_rdata` holds that value until the next read.
- R10: `reg_wr` without `reg_sel` changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel | input | 1 | Register address decode hit |
| reg_wr | input | 1 | Write enable, qualified by `reg_sel` |
| reg_wdata | input | 32 | Write data; only bits 5:0 are stored |
| reg_rdata | output | 32 | Registered read data |
| done_pulse | input | 1 | One-cycle transfer completion pulse from the channel |
| irq | output | 1 | Interrupt request, registered |

## Verification
A completion or an acknowledge write shows on `irq` after the first rising edge that samples it, and not before. The count and acknowledge values reach `reg_rdata` only through a read, one edge after the select is sampled. Every task drives its inputs on the falling edge and checks on the following falling edge, half a period after the edge that produced the result. The read-latency check also samples the old `reg_rdata` before that edge, to show the data does not arrive early.

// File: rtl/cack_pkg.sv
package cack_pkg;

    localparam int REG_W       = 32;
    localparam int CNT_W_DEF   = 6;
    localparam int CNT_LSB_DEF = 24;
    localparam int ACK_LSB_DEF = 0;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [REG_W-1:0] wdata;
    } bus_req_t;

    function automatic bus_req_t decode_bus(input logic sel, input logic wr,
                                            input logic [REG_W-1:0] wdata);
        bus_req_t r;
        r.rd    = sel & ~wr;
        r.wr    = sel & wr;
        r.wdata = wdata;
        return r;
    endfunction

endpackage

// File: rtl/cack_evt_counter.sv
module cack_evt_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cnt_nxt_o
);
    logic [W-1:0] cnt_q;

    always_comb begin
        cnt_nxt_o = cnt_q;
        if (inc) cnt_nxt_o = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_nxt_o;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/cack_ack_field.sv
module cack_ack_field #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ack_o,
    output logic [W-1:0] ack_nxt_o
);
    logic [W-1:0] ack_q;

    always_comb begin
        ack_nxt_o = ack_q;
        if (wr_en) ack_nxt_o = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) ack_q <= '0;
        else     ack_q <= ack_nxt_o;
    end

    assign ack_o = ack_q;
endmodule

// File: rtl/cack_readback.sv
module cack_readback #(
    parameter int RW      = 32,
    parameter int W       = 6,
    parameter int CNT_LSB = 24,
    parameter int ACK_LSB = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [W-1:0]  cnt,
    input  logic [W-1:0]  ack,
    output logic [RW-1:0] rdata_o
);
    logic [RW-1:0] word;
    logic [RW-1:0] rdata_q;

    always_comb begin
        word = '0;
        for (int i = 0; i < W; i++) begin
            word[CNT_LSB + i] = cnt[i];
            word[ACK_LSB + i] = ack[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= word;
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/cack_irq_reg.sv
module cack_irq_reg
    import cack_pkg::*;
#(
    parameter int CNT_W   = CNT_W_DEF,
    parameter int CNT_LSB = CNT_LSB_DEF,
    parameter int ACK_LSB = ACK_LSB_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             done_pulse,
    output logic             irq
);
    bus_req_t req;
    logic [CNT_W-1:0] cnt_q, cnt_nxt, ack_q, ack_nxt;
    logic irq_q;
    logic unused_wbits;

    assign req          = decode_bus(reg_sel, reg_wr, reg_wdata);
    assign unused_wbits = ^req.wdata;

    cack_evt_counter #(.W(CNT_W)) cnt_i (
        .clk(clk), .rst(rst), .inc(done_pulse),
        .cnt_o(cnt_q), .cnt_nxt_o(cnt_nxt)
    );

    cack_ack_field #(.W(CNT_W)) ack_i (
        .clk(clk), .rst(rst), .wr_en(req.wr),
        .wdata(req.wdata[ACK_LSB +: CNT_W]),
        .ack_o(ack_q), .ack_nxt_o(ack_nxt)
    );

    cack_readback #(.RW(REG_W), .W(CNT_W), .CNT_LSB(CNT_LSB), .ACK_LSB(ACK_LSB)) rb_i (
        .clk(clk), .rst(rst), .rd_en(req.rd),
        .cnt(cnt_q), .ack(ack_q), .rdata_o(reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= (cnt_nxt != ack_nxt);
    end

    assign irq = irq_q;
endmodule

// File: rtl/cack_irq_reg_chk.sv
module cack_irq_reg_chk #(
    parameter int RW      = 32,
    parameter int CNT_W   = 6,
    parameter int CNT_LSB = 24,
    parameter int ACK_LSB = 0
) (
    input logic             clk,
    input logic             rst,
    input logic             done,
    input logic             sel,
    input logic             wr,
    input logic [CNT_W-1:0] wack,
    input logic [RW-1:0]    rdata,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] ack
);
    logic [RW-1:0] live_mask;
    always_comb begin
        live_mask = '0;
        for (int i = 0; i < CNT_W; i++) begin
            live_mask[CNT_LSB + i] = 1'b1;
            live_mask[ACK_LSB + i] = 1'b1;
        end
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

    assert_count_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(cnt));

    assert_irq_match_R4: assert property (@(posedge clk) disable iff (rst)
        irq == (cnt != ack));

    assert_ack_load_R5: assert property (@(posedge clk) disable iff (rst)
        (sel && wr) |=> ack == $past(wack));

    assert_ack_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(sel && wr) |=> $stable(ack));

    assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rdata & ~live_mask) == '0);

    assert_race_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (done && sel && wr && wack == cnt) |=> irq);

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(sel && !wr) |=> $stable(rdata));
endmodule

bind cack_irq_reg cack_irq_reg_chk #(
    .RW(cack_pkg::REG_W), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB), .ACK_LSB(ACK_LSB)
) chk_i (
    .clk(clk), .rst(rst), .done(done_pulse), .sel(reg_sel), .wr(reg_wr),
    .wack(reg_wdata[ACK_LSB +: CNT_W]), .rdata(reg_rdata), .irq(irq),
    .cnt(cnt_q), .ack(ack_q)
);

// File: tb/cack_irq_reg_tb.sv
`timescale 1ns/1ps
module cack_irq_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        done_pulse = 1'b0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_cnt = 0;
    int exp_ack = 0;

    always #2.5 clk = ~clk;

    cack_irq_reg dut_i (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .done_pulse(done_pulse), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input int c, input int a);
        return {2'b00, 6'(c), 18'd0, 6'(a)};
    endfunction

    task automatic pulse();
        @(negedge clk); done_pulse = 1'b1;
        @(negedge clk); done_pulse = 1'b0;
        exp_cnt = (exp_cnt + 1) % 64;
    endtask

    task automatic wr_reg(input logic [31:0] d);
        @(negedge clk); reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        exp_ack = int'(d[5:0]);
    endtask

    task automatic rd_reg(output logic [31:0] d);
        @(negedge clk); reg_sel = 1'b1; reg_wr = 1'b0;
        @(negedge clk); reg_sel = 1'b0;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        check("R1 rdata", reg_rdata, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);
        @(negedge clk); rst = 1'b0;
        check("R1 irq after release", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_count();
        logic [31:0] d;
        pulse();
        check("R4 irq after first completion", {31'd0, irq}, 32'd1);
        pulse(); pulse();
        rd_reg(d);
        check("R2 count of three", d, word(exp_cnt, exp_ack));
    endtask

    task automatic t_ack();
        logic [31:0] d;
        wr_reg(32'd3);
        check("R4 irq cleared by matching ack", {31'd0, irq}, 32'd0);
        rd_reg(d);
        check("R5 ack readback", d, word(exp_cnt, exp_ack));
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        wr_reg(32'hFFFF_FFC5);
        check("R4 irq on mismatched ack", {31'd0, irq}, 32'd1);
        rd_reg(d);
        check("R6 count unchanged, R7 reserved zero", d, word(3, 5));
        wr_reg(32'd3);
        check("R4 irq low again", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_nosel();
        logic [31:0] d;
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 32'd7;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
        check("R10 irq unchanged", {31'd0, irq}, 32'd0);
        rd_reg(d);
        check("R10 ack unchanged", d, word(exp_cnt, exp_ack));
    endtask

    task automatic t_race();
        logic [31:0] d;
        pulse();
        rd_reg(d);
        check("R2 count four", d, word(exp_cnt, exp_ack));
        @(negedge clk);
        done_pulse = 1'b1; reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = {26'd0, d[29:24]};
        @(negedge clk);
        done_pulse = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        exp_cnt = exp_cnt + 1; exp_ack = int'(d[29:24]);
        check("R8 irq kept", {31'd0, irq}, 32'd1);
        rd_reg(d);
        check("R8 count advanced", d, word(exp_cnt, exp_ack));
        wr_reg(32'(exp_cnt));
        check("R8 irq cleared after second ack", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_latency();
        logic [31:0] prev, d;
        prev = reg_rdata;
        pulse();
        check("R9 rdata holds", reg_rdata, prev);
        @(negedge clk); reg_sel = 1'b1; reg_wr = 1'b0;
        #2;
        check("R9 no early data", reg_rdata, prev);
        @(negedge clk); reg_sel = 1'b0;
        d = reg_rdata;
        check("R9 data one edge later", d, word(exp_cnt, exp_ack));
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        while (exp_cnt != 63) pulse();
        rd_reg(d);
        check("R3 count at 63", d, word(63, exp_ack));
        wr_reg(32'd63);
        check("R3 irq low at 63", {31'd0, irq}, 32'd0);
        pulse();
        check("R3 irq after wrap", {31'd0, irq}, 32'd1);
        rd_reg(d);
        check("R3 count wrapped to zero", d, word(0, 63));
        wr_reg(32'd0);
        check("R3 irq cleared at zero", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                t_count();
                t_ack();
                t_readonly();
                t_nosel();
                t_race();
                t_latency();
                t_wrap();
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule